// File: doc/BRIEF.md
# Port-Output Execution Unit

This unit carries out a processor's write-to-port instructions once they have been decoded. When `start` is pulsed it samples an opcode byte, an 8-bit immediate, the DX register, the accumulator, the operand-size attribute and the current privilege state. From these it works out a 16-bit port number and a transfer size of 1, 2 or 4 bytes. It then either issues one write on the I/O bus or reports a general-protection fault with error code zero.

A permission check is made only when protection is enabled and the program is less privileged than the I/O privilege level, or when virtual-8086 mode is active. For the check the unit reads one permission bit for each byte-port covered by the access, through a request/valid lookup port. It reads the ports in ascending order and stops at the first bit that is set. After a write is acknowledged, the unit holds back its completion pulse until the write-buffer-empty input has been seen high. This means the next instruction cannot start before the posted data has drained.

Top module: `portout_exec`

## Requirements
- R1: Opcode 0xE6 or 0xEE moves one byte. `io_be` is 4'b0001 and `io_data` carries acc[7:0], with bits 31:8 zero.
- R2: Opcode 0xE7 or 0xEF moves two bytes when `opsize32`=0 (`io_be`=4'b0011, `io_data`=acc[15:0] zero-extended) and four bytes when `opsize32`=1 (`io_be`=4'b1111, `io_data`=acc).
- R3: Opcodes 0xE6/0xE7 address port {8'h00, imm8}. Opcodes 0xEE/0xEF address port `dx`.
- R4: The permission lookup is used only when pe=1 and (cpl>iopl or vm=1). Otherwise no `perm_req` is raised and the write is issued. In virtual-8086 mode the lookup applies whatever the values of cpl and iopl.
- R5: A checked access of N bytes at port P requests indices P, P+1, …, P+N-1 (modulo 65536) one at a time in that order. Each request is held until `perm_vld`, and the walk stops at the first index whose `perm_bit` is 1.
- R6: A set permission bit produces a `fault` pulse one cycle after the `perm_vld` that returned it. No I/O write and no `done` follow for that instruction.
- R7: `io_stb` stays high, with `io_addr`, `io_data` and `io_be` unchanged, until the cycle in which `io_ack` is sampled high.
- R8: After `io_ack`, `done` rises one cycle after the first clock edge at which the unit is waiting and `wbe` is sampled high. It never rises before that.
- R9: Each accepted instruction yields exactly one single-cycle pulse of either `done` or `fault`, never both. `err_code` reads zero whenever `fault` is high.
- R10: A `start` with any opcode other than 0xE6, 0xE7, 0xEE or 0xEF, or a `start` while `busy` is high, is ignored. It causes no lookup, no bus write and no `done` or `fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin executing the presented instruction |
| opcode | input | 8 | Decoded opcode byte |
| imm8 | input | 8 | Immediate port operand |
| dx | input | 16 | DX register value |
| acc | input | 32 | Accumulator value |
| opsize32 | input | 1 | Operand-size attribute, 1 = 32-bit |
| pe | input | 1 | Protection enabled |
| cpl | input | 2 | Current privilege level |
| iopl | input | 2 | I/O privilege level |
| vm | input | 1 | Virtual-8086 mode |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Completion pulse |
| fault | output | 1 | General-protection fault pulse |
| err_code | output | 16 | Fault error code (zero) |
| perm_req | output | 1 | Permission lookup request |
| perm_idx | output | 16 | Port index being looked up |
| perm_vld | input | 1 | Lookup result valid |
| perm_bit | input | 1 | Permission bit, 1 = denied |
| io_stb | output | 1 | I/O write strobe |
| io_addr | output | 16 | I/O port address |
| io_data | output | 32 | I/O write data |
| io_be | output | 4 | Byte enables |
| io_ack | input | 1 | I/O write acknowledge |
| wbe | input | 1 | Write buffer empty |

## Verification
A corrupted walk counter shows up straight away on `perm_idx`: the port index in the next lookup is off, or the walk goes one lookup too far or too short before the write or the fault. A wrong sequencer state appears at the bus within a cycle or two. It can show as a strobe that drops before acknowledge, a write that follows a denied bit, or a `done` that comes before `wbe`. The bench models each instruction behaviourally and compares the lookup index stream, the bus write fields and the exact cycle of `done` or `fault` against that model. It also checks pulse shape on every clock.

// File: rtl/portout_pkg.sv
package portout_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_WRITE = 2'd2,
    ST_DRAIN = 2'd3
  } pout_state_e;

  localparam logic [7:0] OPC_IMM_BYTE = 8'hE6;
  localparam logic [7:0] OPC_IMM_SIZED = 8'hE7;
  localparam logic [7:0] OPC_DX_BYTE  = 8'hEE;
  localparam logic [7:0] OPC_DX_SIZED = 8'hEF;
endpackage

// File: rtl/portout_decode.sv
module portout_decode
  import portout_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int PL_W   = 2,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic [7:0]        opcode,
  input  logic [7:0]        imm8,
  input  logic [ADDR_W-1:0] dx,
  input  logic [DATA_W-1:0] acc,
  input  logic              opsize32,
  input  logic              pe,
  input  logic [PL_W-1:0]   cpl,
  input  logic [PL_W-1:0]   iopl,
  input  logic              vm,
  output logic              legal,
  output logic              need_chk,
  output logic [ADDR_W-1:0] addr,
  output logic [1:0]        last_off,
  output logic [BE_W-1:0]   be,
  output logic [DATA_W-1:0] data
);
  logic use_dx;
  logic sized;

  always_comb begin
    legal  = (opcode == OPC_IMM_BYTE) || (opcode == OPC_IMM_SIZED) ||
             (opcode == OPC_DX_BYTE)  || (opcode == OPC_DX_SIZED);
    use_dx = (opcode == OPC_DX_BYTE) || (opcode == OPC_DX_SIZED);
    sized  = (opcode == OPC_IMM_SIZED) || (opcode == OPC_DX_SIZED);
    addr   = use_dx ? dx : {{(ADDR_W-8){1'b0}}, imm8};
    if (!sized)        last_off = 2'd0;
    else if (opsize32) last_off = 2'd3;
    else               last_off = 2'd1;
    need_chk = pe && ((cpl > iopl) || vm);
  end

  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    localparam int unsigned LANE = g;
    assign be[g]            = (LANE <= 32'(last_off));
    assign data[8*g +: 8]   = be[g] ? acc[8*g +: 8] : 8'h00;
  end
endmodule

// File: rtl/portout_perm_walk.sv
module portout_perm_walk #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic [1:0]        last_off,
  input  logic              step,
  output logic [ADDR_W-1:0] idx,
  output logic              at_last
);
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        last_q;
  logic [1:0]        off_q;
  logic [1:0]        off_n;

  always_comb begin
    off_n = off_q;
    if (load)      off_n = 2'd0;
    else if (step) off_n = off_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      last_q <= '0;
      off_q  <= '0;
    end else begin
      if (load) begin
        base_q <= base;
        last_q <= last_off;
      end
      if (load || step) off_q <= off_n;
    end
  end

  assign idx     = base_q + ADDR_W'(off_q);
  assign at_last = (off_q == last_q);
endmodule

// File: rtl/portout_exec.sv
module portout_exec
  import portout_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int PL_W   = 2,
  parameter int ERR_W  = 16,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic [7:0]        imm8,
  input  logic [ADDR_W-1:0] dx,
  input  logic [DATA_W-1:0] acc,
  input  logic              opsize32,
  input  logic              pe,
  input  logic [PL_W-1:0]   cpl,
  input  logic [PL_W-1:0]   iopl,
  input  logic              vm,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [ERR_W-1:0]  err_code,
  output logic              perm_req,
  output logic [ADDR_W-1:0] perm_idx,
  input  logic              perm_vld,
  input  logic              perm_bit,
  output logic              io_stb,
  output logic [ADDR_W-1:0] io_addr,
  output logic [DATA_W-1:0] io_data,
  output logic [BE_W-1:0]   io_be,
  input  logic              io_ack,
  input  logic              wbe
);
  // reset: asserted at once, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic              dec_legal, dec_chk;
  logic [ADDR_W-1:0] dec_addr;
  logic [1:0]        dec_last;
  logic [BE_W-1:0]   dec_be;
  logic [DATA_W-1:0] dec_data;

  portout_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PL_W(PL_W)) u_dec (
    .opcode(opcode), .imm8(imm8), .dx(dx), .acc(acc), .opsize32(opsize32),
    .pe(pe), .cpl(cpl), .iopl(iopl), .vm(vm),
    .legal(dec_legal), .need_chk(dec_chk), .addr(dec_addr),
    .last_off(dec_last), .be(dec_be), .data(dec_data)
  );

  pout_state_e st_q, st_n;
  logic        accept, walk_step, walk_last, done_n, fault_n;

  portout_perm_walk #(.ADDR_W(ADDR_W)) u_walk (
    .clk(clk), .rst_n(rst_int_n), .load(accept), .base(dec_addr),
    .last_off(dec_last), .step(walk_step), .idx(perm_idx), .at_last(walk_last)
  );

  // next-state logic
  always_comb begin
    st_n      = st_q;
    accept    = 1'b0;
    walk_step = 1'b0;
    done_n    = 1'b0;
    fault_n   = 1'b0;
    case (st_q)
      ST_IDLE: if (start && dec_legal) begin
        accept = 1'b1;
        st_n   = dec_chk ? ST_CHECK : ST_WRITE;
      end
      ST_CHECK: if (perm_vld) begin
        if (perm_bit) begin
          fault_n = 1'b1;
          st_n    = ST_IDLE;
        end else if (walk_last) begin
          st_n = ST_WRITE;
        end else begin
          walk_step = 1'b1;
        end
      end
      ST_WRITE: if (io_ack) st_n = ST_DRAIN;
      ST_DRAIN: if (wbe) begin
        done_n = 1'b1;
        st_n   = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  logic [ADDR_W-1:0] addr_q;
  logic [BE_W-1:0]   be_q;
  logic [DATA_W-1:0] data_q;
  logic              done_q, fault_q;

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      be_q    <= '0;
      data_q  <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      done_q  <= done_n;
      fault_q <= fault_n;
      if (accept) begin
        addr_q <= dec_addr;
        be_q   <= dec_be;
        data_q <= dec_data;
      end
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign perm_req = (st_q == ST_CHECK);
  assign io_stb   = (st_q == ST_WRITE);
  assign io_addr  = addr_q;
  assign io_data  = data_q;
  assign io_be    = be_q;
  assign done     = done_q;
  assign fault    = fault_q;
  assign err_code = '0;
endmodule

// File: rtl/portout_exec_chk.sv
module portout_exec_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              fault,
  input logic              wbe,
  input logic              perm_req,
  input logic              perm_vld,
  input logic              perm_bit,
  input logic              io_stb,
  input logic              io_ack,
  input logic [ADDR_W-1:0] io_addr,
  input logic [DATA_W-1:0] io_data,
  input logic [BE_W-1:0]   io_be
);
  p_be_shape_r1: assert property (@(posedge clk) disable iff (!rst_n)
    io_stb |-> (io_be == 4'b0001 || io_be == 4'b0011 || io_be == 4'b1111));

  p_deny_faults_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (perm_req && perm_vld && perm_bit) |=> fault);

  p_deny_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (perm_req && perm_vld && perm_bit) |=> !io_stb);

  p_strobe_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (io_stb && !io_ack) |=> (io_stb && $stable(io_addr) && $stable(io_data) && $stable(io_be)));

  p_done_after_wbe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wbe));

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !fault);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_fault_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> (!io_stb && !perm_req));
endmodule

bind portout_exec portout_exec_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .fault(fault), .wbe(wbe), .perm_req(perm_req), .perm_vld(perm_vld),
  .perm_bit(perm_bit), .io_stb(io_stb), .io_ack(io_ack), .io_addr(io_addr),
  .io_data(io_data), .io_be(io_be)
);

// File: tb/portout_exec_tb_top.sv
module portout_exec_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [7:0]  imm8 = 8'h00;
  logic [15:0] dx = 16'h0;
  logic [31:0] acc = 32'h0;
  logic        opsize32 = 1'b0;
  logic        pe = 1'b0;
  logic [1:0]  cpl = 2'd0;
  logic [1:0]  iopl = 2'd0;
  logic        vm = 1'b0;
  logic        busy, done, fault, perm_req, io_stb;
  logic [15:0] err_code, perm_idx, io_addr;
  logic [31:0] io_data;
  logic [3:0]  io_be;
  logic        perm_vld = 1'b0;
  logic        perm_bit = 1'b0;
  logic        io_ack = 1'b0;
  logic        wbe = 1'b1;

  always #2.5 clk = ~clk;

  portout_exec dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .imm8(imm8),
    .dx(dx), .acc(acc), .opsize32(opsize32), .pe(pe), .cpl(cpl), .iopl(iopl),
    .vm(vm), .busy(busy), .done(done), .fault(fault), .err_code(err_code),
    .perm_req(perm_req), .perm_idx(perm_idx), .perm_vld(perm_vld),
    .perm_bit(perm_bit), .io_stb(io_stb), .io_addr(io_addr), .io_data(io_data),
    .io_be(io_be), .io_ack(io_ack), .wbe(wbe)
  );

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;

  bit bm [int];
  int perm_lat = 0, io_lat = 0, wbe_dly = 0;
  int pwait = 0, iwait = 0, wcnt = 0;
  int plog[$];
  int last_pv_cyc = 0, ack_cyc = 0, done_cyc = 0, fault_cyc = 0;
  int n_done = 0, n_fault = 0, n_wr = 0, n_req_cyc = 0;
  logic [15:0] w_addr;
  logic [31:0] w_data;
  logic [3:0]  w_be;
  logic        prev_done = 0, prev_fault = 0, prev_stb = 0;
  logic [15:0] s_addr;
  logic [31:0] s_data;
  logic [3:0]  s_be;

  function automatic bit bmget(int i);
    return bm.exists(i) ? bm[i] : 1'b0;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // cycle monitor and bus responders
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "WDOG", "watchdog expired", cyc, 150000);
      finish_run();
    end
    if (rst_n) begin
      chk(!(done && fault), "R9", "done and fault together", {done, fault}, 0);
      if (done) begin
        chk(!prev_done, "R9", "done wider than one cycle", 1, 0);
        n_done++; done_cyc = cyc;
      end
      if (fault) begin
        chk(!prev_fault, "R9", "fault wider than one cycle", 1, 0);
        chk(err_code == 16'h0, "R9", "error code", err_code, 0);
        n_fault++; fault_cyc = cyc;
      end
      if (io_stb && prev_stb)
        chk(io_addr == s_addr && io_data == s_data && io_be == s_be, "R7",
            "strobe fields moved", io_addr, s_addr);
      if (perm_req) n_req_cyc++;
    end
    prev_done  = done;
    prev_fault = fault;
    prev_stb   = io_stb && !io_ack;
    s_addr = io_addr; s_data = io_data; s_be = io_be;
    // permission lookup responder
    if (perm_vld) begin
      perm_vld = 1'b0;
    end else if (perm_req) begin
      if (pwait < perm_lat) pwait++;
      else begin
        perm_vld = 1'b1;
        perm_bit = bmget(int'(perm_idx));
        plog.push_back(int'(perm_idx));
        last_pv_cyc = cyc;
        pwait = 0;
      end
    end
    // bus responder and write-buffer model
    if (io_ack) begin
      io_ack = 1'b0;
      if (!wbe) begin wcnt++; if (wcnt >= wbe_dly) wbe = 1'b1; end
    end else begin
      if (!wbe) begin wcnt++; if (wcnt >= wbe_dly) wbe = 1'b1; end
      if (io_stb) begin
        if (iwait < io_lat) iwait++;
        else begin
          io_ack = 1'b1;
          w_addr = io_addr; w_data = io_data; w_be = io_be;
          n_wr++; ack_cyc = cyc; iwait = 0;
          wcnt = 0;
          wbe = (wbe_dly == 0);
        end
      end
    end
  end

  task automatic run(string tag, logic [7:0] opc, logic [7:0] im, logic [15:0] dxv,
                     logic [31:0] a, bit os, bit p, int c, int io, bit v,
                     int plat, int ilat, int wd, bit mid);
    bit legal, chkd, flt;
    int nb, port;
    int exp_idx[$];
    logic [31:0] mask;
    logic [3:0] ebe;
    legal = (opc == 8'hE6 || opc == 8'hE7 || opc == 8'hEE || opc == 8'hEF);
    nb    = (opc == 8'hE6 || opc == 8'hEE) ? 1 : (os ? 4 : 2);
    port  = (opc == 8'hEE || opc == 8'hEF) ? int'(dxv) : int'(im);
    chkd  = p && ((c > io) || v);
    flt   = 1'b0;
    if (legal && chkd)
      for (int k = 0; k < nb; k++) begin
        exp_idx.push_back((port + k) & 16'hFFFF);
        if (bmget((port + k) & 16'hFFFF)) begin flt = 1'b1; break; end
      end
    mask = (nb == 1) ? 32'hFF : (nb == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
    ebe  = (nb == 1) ? 4'b0001 : (nb == 2) ? 4'b0011 : 4'b1111;

    @(negedge clk); #1;
    plog.delete();
    n_done = 0; n_fault = 0; n_wr = 0; n_req_cyc = 0;
    perm_lat = plat; io_lat = ilat; wbe_dly = wd;
    opcode = opc; imm8 = im; dx = dxv; acc = a; opsize32 = os;
    pe = p; cpl = 2'(c); iopl = 2'(io); vm = v;
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    for (int i = 0; i < 300; i++) begin
      if (mid && i == 2) begin opcode = 8'hE6; imm8 = 8'h01; start = 1'b1; end
      else start = 1'b0;
      @(negedge clk); #1;
      if (n_done + n_fault > 0 && !mid) break;
      if (!legal && i > 20) break;
      if (mid && i > 60) break;
    end
    start = 1'b0;
    repeat (4) @(negedge clk);
    #1;

    if (!legal) begin
      chk(n_req_cyc == 0, "R10", {tag, " lookup after illegal opcode"}, n_req_cyc, 0);
      chk(n_wr == 0, "R10", {tag, " write after illegal opcode"}, n_wr, 0);
      chk(n_done + n_fault == 0, "R10", {tag, " pulse after illegal opcode"}, n_done + n_fault, 0);
      return;
    end
    chk(n_done + n_fault == 1, "R9", {tag, " pulse count"}, n_done + n_fault, 1);
    chk(plog.size() == exp_idx.size(), chkd ? "R5" : "R4", {tag, " lookup count"},
        plog.size(), exp_idx.size());
    for (int k = 0; k < plog.size() && k < exp_idx.size(); k++)
      chk(plog[k] == exp_idx[k], "R5", {tag, " lookup index"}, plog[k], exp_idx[k]);
    if (flt) begin
      chk(n_fault == 1 && n_done == 0, "R6", {tag, " fault expected"}, n_fault, 1);
      chk(n_wr == 0, "R6", {tag, " write after denial"}, n_wr, 0);
      chk(fault_cyc == last_pv_cyc + 1, "R6", {tag, " fault cycle"}, fault_cyc, last_pv_cyc + 1);
    end else begin
      chk(n_done == 1 && n_fault == 0, "R4", {tag, " completion expected"}, n_done, 1);
      chk(n_wr == 1, "R4", {tag, " write count"}, n_wr, 1);
      chk(w_addr == 16'(port), "R3", {tag, " port address"}, w_addr, port);
      chk(w_be == ebe, nb == 1 ? "R1" : "R2", {tag, " byte enables"}, w_be, ebe);
      chk(w_data == (a & mask), nb == 1 ? "R1" : "R2", {tag, " write data"}, w_data, a & mask);
      chk(done_cyc == ack_cyc + ((wd < 1) ? 1 : wd) + 1, "R8", {tag, " done cycle"},
          done_cyc, ack_cyc + ((wd < 1) ? 1 : wd) + 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(!busy && !done && !fault && !io_stb && !perm_req, "R9", "reset state",
        {busy, done, fault, io_stb, perm_req}, 0);

    bm[16'hBEF1] = 1'b1;
    bm[16'h0080] = 1'b1;
    bm[16'h0300] = 1'b1;

    // R1 R3 R4: real mode, byte to immediate port
    run("imm-byte-real", 8'hE6, 8'h5A, 16'hFFFF, 32'h1122_3344, 0, 0, 3, 0, 0, 0, 0, 1, 0);
    // R3 R4: DX byte, protected with cpl <= iopl
    run("dx-byte-priv", 8'hEE, 8'h00, 16'h1234, 32'hA5A5_A5C3, 1, 1, 0, 3, 0, 1, 1, 2, 0);
    // R2 R5: 16-bit immediate, checked, all clear
    run("imm-word-chk", 8'hE7, 8'h40, 16'h0000, 32'hDEAD_3344, 0, 1, 3, 0, 0, 2, 0, 1, 0);
    // R2 R5 R6: 32-bit DX, third byte denied
    run("dx-dword-deny", 8'hEF, 8'h00, 16'hBEEF, 32'h0102_0304, 1, 1, 3, 1, 0, 0, 0, 1, 0);
    // R4 R6: virtual-8086 ignores iopl, first byte denied
    run("v86-deny", 8'hE6, 8'h80, 16'h0000, 32'h0000_0077, 0, 1, 0, 3, 1, 1, 0, 1, 0);
    // R4: cpl == iopl, set bit not consulted
    run("eq-priv-nochk", 8'hEE, 8'h00, 16'h0300, 32'h0000_00AB, 0, 1, 2, 2, 0, 0, 0, 1, 0);
    // R5: index wraps past 65535
    run("wrap-walk", 8'hEF, 8'h00, 16'hFFFE, 32'hCAFE_F00D, 1, 1, 1, 0, 0, 0, 2, 3, 0);
    // R7 R8: slow ack and slow drain
    run("slow-bus", 8'hE7, 8'h10, 16'h0000, 32'h8765_4321, 1, 0, 0, 0, 0, 0, 4, 6, 0);
    // R8: buffer already empty
    run("wbe-ready", 8'hEE, 8'h00, 16'h0055, 32'h0000_0099, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R10: illegal opcode
    run("bad-opcode", 8'hEC, 8'h12, 16'h0012, 32'h1, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    // R10: start while busy is ignored
    run("busy-restart", 8'hEF, 8'h00, 16'h2000, 32'h5555_AAAA, 1, 1, 3, 0, 0, 1, 3, 8, 1);

    finish_run();
  end
endmodule